// File: doc/BRIEF.md
# Stereo Tremolo Amplitude Modulator

This block applies amplitude modulation to a stereo stream of signed samples. Each channel is scaled by an unsigned gain taken from an externally generated low-frequency oscillator. Because the gain is unsigned, the output keeps the sign of the input at all times. This is the property that separates tremolo from ring modulation.

The left channel always uses the oscillator value as it arrives. The right channel uses either the same value or its bitwise inverse. With the same value, both channels swell and fade together. With the inverse, one channel grows louder while the other fades, so the sound pans back and forth.

A raw, active-low pushbutton toggles between the two modes. The button is looked at only on a slow control tick, which comes once every `CTRL_DIV` sample strobes. It is debounced by an edge-seen flag. Each strobe produces one registered output pair with a one-cycle valid pulse.

Top module: `stereo_tremolo`

## Requirements
- R1: After reset, `out_valid` is 0, both outputs are 0, and the mode is antiphase, so the first sample's right channel uses the inverted gain.
- R2: On a strobe, `out_left` is the upper `SW` bits of the `SW+LW`-bit product of `in_left` (two's complement) and `lfo` (unsigned). This is an arithmetic right shift by `LW` that rounds toward minus infinity.
- R3: In in-phase mode, `out_right` is formed from `in_right` and `lfo` by the rule of R2.
- R4: In antiphase mode, `out_right` is formed from `in_right` and `~lfo` (ones complement, not negation) by the rule of R2.
- R5: Each strobe on `in_valid` gives exactly one `out_valid` pulse, one cycle later, carrying both channels. No pulse appears without a strobe, and back-to-back strobes give back-to-back pulses.
- R6: `btn_n` is sampled only on the control tick, which is the strobe whose index is a multiple of `CTRL_DIV` minus one, counting strobes from 0 after reset. A low level on any other strobe or cycle has no effect.
- R7: On a tick with `btn_n` low and no press recorded, the mode toggles and a press is recorded. A tick with `btn_n` high clears the record. A tick with `btn_n` low and a press already recorded leaves the mode unchanged.
- R8: A mode change on a tick takes effect from the next strobe. The tick strobe's own sample still uses the old mode.
- R9: A nonzero output never has the opposite sign of its input sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_left | input | SW | Left input sample, signed |
| in_right | input | SW | Right input sample, signed |
| lfo | input | LW | Oscillator gain, unsigned |
| btn_n | input | 1 | Raw mode button, low when pressed |
| out_valid | output | 1 | Output pair valid, one cycle per strobe |
| out_left | output | SW | Modulated left sample |
| out_right | output | SW | Modulated right sample |

## Verification
The bench keeps the 16-bit sample and gain widths and builds the block with `CTRL_DIV` set to 4 instead of 256. This puts many control ticks within a short run. It makes it possible to hold the button low on non-tick strobes only, to hold it across several ticks, and to release and press it again, while every sample still checks both channels against the mode the bench expects. Extreme samples and gains (full-scale negative, zero and all-ones gain) exercise the rounding and the sign rule.

// File: rtl/stereo_tremolo.sv
module stereo_tremolo #(
  parameter int SW       = 16,
  parameter int LW       = 16,
  parameter int CTRL_DIV = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [SW-1:0] in_left,
  input  logic [SW-1:0] in_right,
  input  logic [LW-1:0] lfo,
  input  logic          btn_n,
  output logic          out_valid,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right
);

  localparam int CW = (CTRL_DIV > 1) ? $clog2(CTRL_DIV) : 1;
  localparam int PW = SW + LW + 1;

  logic [CW-1:0] cnt;
  logic          seen;
  logic          anti;
  logic          tick;
  logic [LW-1:0] gain_r;

  logic signed [PW-1:0] prod_l;
  logic signed [PW-1:0] prod_r;

  assign tick   = in_valid && (cnt == CW'(CTRL_DIV - 1));
  assign gain_r = anti ? ~lfo : lfo;
  assign prod_l = $signed(in_left)  * $signed({1'b0, lfo});
  assign prod_r = $signed(in_right) * $signed({1'b0, gain_r});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
      anti <= 1'b1;
    end else if (in_valid) begin
      if (tick) begin
        cnt <= '0;
        if (btn_n) begin
          seen <= 1'b0;
        end else if (!seen) begin
          seen <= 1'b1;
          anti <= ~anti;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= SW'(prod_l >>> LW);
        out_right <= SW'(prod_r >>> LW);
      end
    end
  end

  p_valid_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_mode_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(anti));

  p_held_no_retoggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && !btn_n) |=> $stable(anti));

  p_inphase_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !anti && in_left == in_right) |=> out_left == out_right);

  p_left_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !(out_left[SW-1] && !$past(in_left[SW-1])));

  p_right_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !(out_right[SW-1] && !$past(in_right[SW-1])));

endmodule

// File: tb/tb_stereo_tremolo.sv
module tb_stereo_tremolo;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_left = '0, in_right = '0, lfo = '0;
  logic        btn_n = 1'b1;
  logic        out_valid;
  logic [15:0] out_left, out_right;

  int errors = 0;
  int checks = 0;
  int sent = 0;
  int got = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  int m_cnt = 0;
  bit m_seen = 0;
  bit m_anti = 1;

  always #4 clk = ~clk;

  stereo_tremolo #(.SW(16), .LW(16), .CTRL_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .lfo(lfo), .btn_n(btn_n), .out_valid(out_valid),
    .out_left(out_left), .out_right(out_right));

  function automatic logic [15:0] scale(logic [15:0] x, logic [15:0] g);
    logic signed [32:0] p;
    p = $signed(x) * $signed({1'b0, g});
    return p[31:16];
  endfunction

  task automatic send(input logic [15:0] l, input logic [15:0] r,
                      input logic [15:0] g, input bit b, input string tag);
    logic [15:0] gr;
    @(negedge clk);
    in_valid = 1'b1; in_left = l; in_right = r; lfo = g; btn_n = b;
    gr = m_anti ? ~g : g;
    exp_q.push_back({scale(l, g), scale(r, gr)});
    tag_q.push_back(tag);
    sent++;
    if (m_cnt == DIV - 1) begin
      m_cnt = 0;
      if (b) m_seen = 0;
      else if (!m_seen) begin m_seen = 1; m_anti = ~m_anti; end
    end else m_cnt++;
    @(negedge clk);
    in_valid = 1'b0; btn_n = 1'b1;
  endtask

  task automatic send_b2b(input int n);
    for (int i = 0; i < n; i++) begin
      logic [15:0] l, r, g, gr;
      l = 16'(i * 4099 - 20000); r = 16'(-i * 777 + 3); g = 16'(i * 9001 + 5);
      @(negedge clk);
      in_valid = 1'b1; in_left = l; in_right = r; lfo = g; btn_n = 1'b1;
      gr = m_anti ? ~g : g;
      exp_q.push_back({scale(l, g), scale(r, gr)});
      tag_q.push_back("R5 back-to-back");
      sent++;
      if (m_cnt == DIV - 1) begin m_cnt = 0; m_seen = 0; end else m_cnt++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic align();
    while (m_cnt != 0) send(16'h0123, 16'hFEDC, 16'h4000, 1'b1, "R6 align");
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      logic [31:0] e;
      string t;
      got++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5: unexpected valid, got %h/%h expected none", out_left, out_right);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({out_left, out_right} !== e) begin
          errors++;
          $display("FAIL %s: got L=%h R=%h expected L=%h R=%h", t,
                   out_left, out_right, e[31:16], e[15:0]);
        end
      end
    end
  end

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_left !== 16'h0 || out_right !== 16'h0) begin
      errors++;
      $display("FAIL R1: got v=%b L=%h R=%h expected 0 0 0", out_valid, out_left, out_right);
    end
    rst_n = 1'b1;
    send(16'd1000, 16'd1000, 16'h8000, 1'b1, "R1 antiphase after reset");
    send(16'h8000, 16'h8000, 16'hFFFF, 1'b1, "R2 R4 full scale negative");
    send(16'h7FFF, 16'hFFFF, 16'h0000, 1'b1, "R2 R4 zero gain");
    send(16'hFFFF, 16'h0001, 16'h0001, 1'b1, "R9 R2 rounding toward minus");
    repeat (5) @(negedge clk);
    checks++;
    if (got != sent) begin
      errors++;
      $display("FAIL R5: got %0d outputs expected %0d", got, sent);
    end
    align();
    send(16'd300, 16'd300, 16'h1234, 1'b0, "R6 low off tick");
    send(16'd301, 16'd301, 16'h2345, 1'b0, "R6 low off tick");
    send(16'd302, 16'd302, 16'h3456, 1'b0, "R6 low off tick");
    send(16'd303, 16'd303, 16'h4567, 1'b1, "R6 high on tick");
    send(16'hC000, 16'h4000, 16'hA000, 1'b1, "R6 R4 mode unchanged");
    align();
    send(16'd10, 16'd10, 16'hF000, 1'b1, "R7");
    send(16'd11, 16'd11, 16'hF000, 1'b1, "R7");
    send(16'd12, 16'd12, 16'hF000, 1'b1, "R7");
    send(16'd5000, 16'd5000, 16'hC000, 1'b0, "R8 tick uses old mode");
    send(16'd5000, 16'd5000, 16'hC000, 1'b0, "R8 R3 in-phase after press");
    for (int i = 0; i < 2 * DIV; i++)
      send(16'(i * 1111 - 3000), 16'(-i * 2222), 16'(i * 7000 + 1), 1'b0, "R7 R3 held no retoggle");
    for (int i = 0; i < DIV; i++)
      send(16'(i * 321), 16'(i * 321), 16'hBEEF, 1'b1, "R7 release");
    for (int i = 0; i < DIV + 1; i++)
      send(16'(-i * 4321), 16'(i * 999), 16'h5A5A, 1'b0, "R7 R4 second press");
    send_b2b(10);
    repeat (5) @(negedge clk);
    checks++;
    if (got != sent || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5: got %0d outputs expected %0d", got, sent);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule